// File: doc/BRIEF.md
# Delta-Sigma Converter Result Reader

This block is the host side of a four-wire serial link to a multichannel delta-sigma converter. After a single-cycle start request it drops chip select and waits for the converter to signal on its data line that the result is ready. It then runs a fixed 32-clock serial frame. During the frame it shifts a 13-bit configuration word out to the converter and captures the 32-bit result word coming back.

The captured word is split into fields and registered. The fields are a framing-error flag, the sign bit, the 24 result bits, a 25-bit two's-complement value, the 5 bits below the LSB, and the over-range and under-range indications. All fields are presented together with a one-cycle completion pulse. If the converter never reports ready, a bounded wait gives up, releases chip select and pulses a timeout strobe instead.

The serial clock is derived from the system clock through a parameterised half-period divider. The delay from chip select low to the first possible clock is also a parameter, so both can be set to meet the converter's minimum timing at any system clock rate.

Top module: `adcrd_host`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, ready is high, and both the completion pulse and the timeout strobe are low.
- R2: A start request seen while ready drops chip select. The serial clock stays low for at least SETUP_CYC cycles after that, and it is low whenever chip select is high.
- R3: While chip select is low and the converter's data line reads high, no serial clock edge is produced. Once the line reads low, clocking begins within HALF_DIV plus a few cycles.
- R4: If the data line stays high for POLL_MAX consecutive poll samples, the block does the following: chip select rises exactly SETUP_CYC+POLL_MAX cycles after it fell, the timeout strobe pulses for one cycle, no serial clock edge is produced, no completion is signalled, and the previously decoded outputs keep their values.
- R5: A frame consists of exactly 32 serial clock pulses, and each high phase and each low phase lasts HALF_DIV system cycles.
- R6: The configuration word is taken when the start request is accepted. It is sent MSB first, valid at rising clock edges 1 to 13, and the data-out line is low at rising edges 14 to 32.
- R7: The incoming word is sampled on rising serial clock edges, first bit as bit 31. The result field is bits 28 to 5 of the word.
- R8: Completion is one cycle long and is given with chip select already high. The decoded outputs are held until the next completion.
- R9: The framing-error flag is set when bit 30 (the always-low bit) or bit 31 (the ready bit) of the captured word is high.
- R10: Over-range is flagged when bits 29 and 28 are both 1. Under-range is flagged when both are 0.
- R11: The sign output equals bit 29. The sub-LSB output equals bits 4 to 0. The signed value equals the 24-bit field when bit 29 is 1, and the field minus 2^24 when bit 29 is 0.
- R12: Start requests that arrive while a read is in progress are ignored. They neither restart the frame nor queue a further read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Read request, taken while ready |
| cfg_i | input | 13 | Configuration word to send |
| ready_o | output | 1 | Idle, a request will be accepted |
| csn_o | output | 1 | Chip select to converter, active low |
| sclk_o | output | 1 | Serial clock to converter |
| mosi_o | output | 1 | Serial data to converter |
| miso_i | input | 1 | Serial data / ready status from converter |
| done_o | output | 1 | One-cycle completion pulse |
| tout_o | output | 1 | One-cycle ready-wait timeout strobe |
| frame_err_o | output | 1 | Status bits 31 or 30 read high |
| sign_o | output | 1 | Sign bit, 1 for positive input |
| over_o | output | 1 | Over-range indication |
| under_o | output | 1 | Under-range indication |
| data_o | output | 24 | Raw 24-bit result field |
| value_o | output | 25 | Signed two's-complement value |
| sub_o | output | 5 | Bits below the result LSB |

## Verification
The bench drives words at both range limits, the values -1 and negative full scale, and a frame with the always-low bit set. A decoder that took the sign bit as a two's-complement sign, or tested only one of the two range bits, would return a wrong value or a wrong flag for one of these words. The ready wait is tried in three ways: ready at once, ready just before the limit, and ready never. A poll counter that is off by one, or a reader that clocks while the converter is still busy, changes the measured chip-select-low time or produces clock edges where none may occur. A second request in the middle of a frame and a changed configuration input after acceptance catch a design that restarts, queues or resamples.

// File: rtl/adcrd_pkg.sv
// Shared constants and types for the converter result reader.
// Assumes the result word layout: ready bit, always-low bit, sign bit,
// 24 result bits, then 5 bits below the result LSB.
package adcrd_pkg;
    localparam int WORD_W = 32;
    localparam int CFG_W  = 13;
    localparam int DATA_W = 24;
    localparam int SUB_W  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_POLL,
        ST_XFER,
        ST_DONE
    } rd_state_t;

    typedef struct packed {
        logic              frame_err;
        logic              sign;
        logic              over;
        logic              under;
        logic [DATA_W-1:0] data;
        logic [DATA_W:0]   value;
        logic [SUB_W-1:0]  sub;
    } rd_fields_t;
endpackage

// File: rtl/adcrd_sck_gen.sv
// Serial clock generator. While run_i is high, it toggles sclk_o every
// HALF_DIV system cycles, starting from low. The rise/fall strobes mark
// the system cycle whose closing edge makes the clock rise or fall.
// Assumes HALF_DIV >= 1. Dropping run_i returns the clock to low at once.
module adcrd_sck_gen #(
    parameter int HALF_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int PH_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [PH_W-1:0] ph_q;
    logic            ph_end;

    assign ph_end = (ph_q == PH_W'(HALF_DIV - 1));

    // Phase counter and clock level; held low and cleared when not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            sclk_o <= 1'b0;
        end else if (!run_i) begin
            ph_q   <= '0;
            sclk_o <= 1'b0;
        end else if (ph_end) begin
            ph_q   <= '0;
            sclk_o <= ~sclk_o;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // Edge strobes for the shift unit.
    assign rise_o = run_i & ph_end & ~sclk_o;
    assign fall_o = run_i & ph_end & sclk_o;
endmodule

// File: rtl/adcrd_shift.sv
// Frame shifter. On load it takes the configuration word into the top of
// the outgoing register, padded with zeros, and clears the capture side.
// It shifts out on clock falls and captures the incoming line on clock
// rises, MSB first, counting captured bits up to W.
// Assumes W > CW.
module adcrd_shift
    import adcrd_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = CFG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] cfg_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          miso_i,
    output logic          mosi_o,
    output logic [W-1:0]  word_o,
    output logic          full_o
);
    localparam int CNT_W = $clog2(W + 1);
    localparam int PAD_W = W - CW;

    logic [W-1:0]     out_q;
    logic [W-1:0]     in_q;
    logic [CNT_W-1:0] cnt_q;

    // Outgoing/incoming shift registers and captured-bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            in_q  <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            out_q <= {cfg_i, {PAD_W{1'b0}}};
            in_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (rise_i && !full_o) begin
                in_q  <= {in_q[W-2:0], miso_i};
                cnt_q <= cnt_q + 1'b1;
            end
            if (fall_i) begin
                out_q <= {out_q[W-2:0], 1'b0};
            end
        end
    end

    assign mosi_o = out_q[W-1];
    assign word_o = in_q;
    assign full_o = (cnt_q == CNT_W'(W));

    // R5: the clock generator never produces a rise once the word is complete.
    a_r5_no_extra_rise: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !rise_i)
        else $error("a_r5_no_extra_rise");
endmodule

// File: rtl/adcrd_decode.sv
// Result-word decoder (combinational). It splits the captured word into
// status flags, the result field, a signed value and the sub-LSB bits.
// Assumes the offset-sign format: the sign bit is 1 for positive inputs, and
// the sign bit together with the result MSB marks the range limits.
module adcrd_decode
    import adcrd_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output rd_fields_t        fields_o
);
    localparam int RDY_B = WORD_W - 1;
    localparam int DMY_B = WORD_W - 2;
    localparam int SGN_B = WORD_W - 3;
    localparam int MSB_B = WORD_W - 4;

    // Field extraction and range/sign decode.
    always_comb begin
        fields_o.frame_err = word_i[RDY_B] | word_i[DMY_B];
        fields_o.sign      = word_i[SGN_B];
        fields_o.data      = word_i[MSB_B -: DATA_W];
        fields_o.over      = word_i[SGN_B] & word_i[MSB_B];
        fields_o.under     = ~(word_i[SGN_B] | word_i[MSB_B]);
        fields_o.value     = {~word_i[SGN_B], word_i[MSB_B -: DATA_W]};
        fields_o.sub       = word_i[SUB_W-1:0];
    end
endmodule

// File: rtl/adcrd_host.sv
// Host-side converter result reader. On start it lowers chip select, waits
// SETUP_CYC cycles and then polls the data line for the ready level (low),
// giving up after POLL_MAX samples. It then runs a 32-clock frame that
// sends the configuration and captures the result, and registers the
// decoded fields with a one-cycle completion pulse.
// Assumes miso_i is synchronous to clk, which holds when the link timing
// is closed at board level.
module adcrd_host
    import adcrd_pkg::*;
#(
    parameter int HALF_DIV  = 8,
    parameter int SETUP_CYC = 13,
    parameter int POLL_MAX  = 100000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [CFG_W-1:0]         cfg_i,
    output logic                     ready_o,
    output logic                     csn_o,
    output logic                     sclk_o,
    output logic                     mosi_o,
    input  logic                     miso_i,
    output logic                     done_o,
    output logic                     tout_o,
    output logic                     frame_err_o,
    output logic                     sign_o,
    output logic                     over_o,
    output logic                     under_o,
    output logic [DATA_W-1:0]        data_o,
    output logic signed [DATA_W:0]   value_o,
    output logic [SUB_W-1:0]         sub_o
);
    localparam int TIM_MAX = (POLL_MAX > SETUP_CYC) ? POLL_MAX : SETUP_CYC;
    localparam int TIM_W   = $clog2(TIM_MAX + 1);

    rd_state_t         st_q;
    logic [TIM_W-1:0]  timer_q;
    logic              tout_q;
    rd_fields_t        fields_q;
    rd_fields_t        dec;
    logic [WORD_W-1:0] word;
    logic              load;
    logic              run;
    logic              rise;
    logic              fall;
    logic              full;

    assign load = (st_q == ST_IDLE) && start_i;
    assign run  = (st_q == ST_XFER);

    adcrd_sck_gen #(
        .HALF_DIV (HALF_DIV)
    ) u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .sclk_o (sclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    adcrd_shift #(
        .W  (WORD_W),
        .CW (CFG_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .cfg_i  (cfg_i),
        .rise_i (rise),
        .fall_i (fall),
        .miso_i (miso_i),
        .mosi_o (mosi_o),
        .word_o (word),
        .full_o (full)
    );

    adcrd_decode u_dec (
        .word_i   (word),
        .fields_o (dec)
    );

    // Sequencer: setup delay, ready poll with timeout, frame, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            timer_q  <= '0;
            tout_q   <= 1'b0;
            fields_q <= '0;
        end else begin
            tout_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q    <= ST_SETUP;
                        timer_q <= '0;
                    end
                end
                ST_SETUP: begin
                    if (timer_q == TIM_W'(SETUP_CYC - 1)) begin
                        st_q    <= ST_POLL;
                        timer_q <= '0;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                ST_POLL: begin
                    if (!miso_i) begin
                        st_q <= ST_XFER;
                    end else if (timer_q == TIM_W'(POLL_MAX - 1)) begin
                        st_q   <= ST_IDLE;
                        tout_q <= 1'b1;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (full && fall) begin
                        st_q     <= ST_DONE;
                        fields_q <= dec;
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Port mapping of state and held fields.
    assign ready_o     = (st_q == ST_IDLE);
    assign csn_o       = (st_q == ST_IDLE) || (st_q == ST_DONE);
    assign done_o      = (st_q == ST_DONE);
    assign tout_o      = tout_q;
    assign frame_err_o = fields_q.frame_err;
    assign sign_o      = fields_q.sign;
    assign over_o      = fields_q.over;
    assign under_o     = fields_q.under;
    assign data_o      = fields_q.data;
    assign value_o     = fields_q.value;
    assign sub_o       = fields_q.sub;

    // R2: serial clock is low whenever chip select is high.
    a_r2_sck_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        csn_o |-> !sclk_o)
        else $error("a_r2_sck_low_idle");

    // R3: no clock while waiting for the ready level.
    a_r3_no_clock_in_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_POLL) |-> !sclk_o)
        else $error("a_r3_no_clock_in_poll");

    // R8: completion lasts one cycle.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("a_r8_done_single");

    // R8: completion is given with chip select released and clock low.
    a_r8_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (csn_o && !sclk_o))
        else $error("a_r8_done_cs_high");

    // R4: a timeout never coincides with completion and leaves the block idle.
    a_r4_tout_clean: assert property (@(posedge clk) disable iff (!rst_n)
        tout_o |-> (!done_o && ready_o))
        else $error("a_r4_tout_clean");
endmodule

// File: tb/adcrd_host_bench.sv
`timescale 1ns/1ps
module adcrd_host_bench;
    localparam int HALF  = 8;
    localparam int SETUP = 13;
    localparam int PMAX  = 60;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [12:0]        cfg_i = '0;
    logic               miso_i = 1'b1;
    logic               ready_o, csn_o, sclk_o, mosi_o, done_o, tout_o;
    logic               frame_err_o, sign_o, over_o, under_o;
    logic [23:0]        data_o;
    logic signed [24:0] value_o;
    logic [4:0]         sub_o;

    int checks = 0;
    int fails  = 0;

    // Converter model state.
    logic [31:0] s_word = '0;
    int          s_busy = 0;
    int          s_idx = 31;
    int          s_cnt = 0;
    logic [31:0] s_cap = '0;
    int          s_rises = 0;
    int          first_gap = -1;
    int          low_cycles = 0;
    int          gap = 0;
    logic        prev_sclk = 1'b0;

    always #2 clk = ~clk;

    adcrd_host #(
        .HALF_DIV  (HALF),
        .SETUP_CYC (SETUP),
        .POLL_MAX  (PMAX)
    ) u_adcrd_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cfg_i       (cfg_i),
        .ready_o     (ready_o),
        .csn_o       (csn_o),
        .sclk_o      (sclk_o),
        .mosi_o      (mosi_o),
        .miso_i      (miso_i),
        .done_o      (done_o),
        .tout_o      (tout_o),
        .frame_err_o (frame_err_o),
        .sign_o      (sign_o),
        .over_o      (over_o),
        .under_o     (under_o),
        .data_o      (data_o),
        .value_o     (value_o),
        .sub_o       (sub_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic dmy, input logic sgn,
                                       input logic [23:0] d, input logic [4:0] s);
        return {1'b0, dmy, sgn, d, s};
    endfunction

    // Converter model and per-clock protocol reference, sampled on falling clk.
    task automatic slave_loop();
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (csn_o) begin
                    chk(sclk_o == 1'b0, "R2", "sclk with cs high", sclk_o, 0);
                    s_idx  = 31;
                    s_cnt  = 0;
                    gap    = 0;
                    miso_i = 1'b1;
                end else begin
                    s_cnt++;
                    low_cycles++;
                    if (sclk_o != prev_sclk) begin
                        if (sclk_o) begin
                            if (s_rises == 0) first_gap = s_cnt;
                            else chk(gap == HALF, "R5", "low phase", gap, HALF);
                            chk(s_cnt > s_busy, "R3", "clock while busy", s_cnt, s_busy + 1);
                            s_cap = {s_cap[30:0], mosi_o};
                            s_rises++;
                        end else begin
                            chk(gap == HALF, "R5", "high phase", gap, HALF);
                            if (s_idx > 0) s_idx--;
                        end
                        gap = 0;
                    end
                    gap++;
                    miso_i = (s_cnt <= s_busy) ? 1'b1 : s_word[s_idx];
                end
            end
            prev_sclk = sclk_o;
        end
    endtask

    task automatic xact(input logic [12:0] cfg, input logic [31:0] word,
                        input int busy, input bit extra_start, input bit exp_tout);
        bit               got_done = 0;
        bit               got_tout = 0;
        longint           exp_val;
        logic signed [24:0] held;
        held       = value_o;
        s_word     = word;
        s_busy     = busy;
        s_rises    = 0;
        s_cap      = '0;
        first_gap  = -1;
        low_cycles = 0;
        @(negedge clk);
        start_i = 1'b1;
        cfg_i   = cfg;
        @(negedge clk);
        start_i = 1'b0;
        cfg_i   = ~cfg;
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            if (extra_start && n == 200) start_i = 1'b1;
            if (extra_start && n == 201) start_i = 1'b0;
            if (done_o) begin got_done = 1; break; end
            if (tout_o) begin got_tout = 1; break; end
        end
        if (exp_tout) begin
            chk(got_tout, "R4", "timeout strobe", got_tout, 1);
            chk(!got_done && !done_o, "R4", "no completion", done_o, 0);
            chk(s_rises == 0, "R4", "no clock edges", s_rises, 0);
            chk(low_cycles == SETUP + PMAX, "R4", "cs low cycles", low_cycles, SETUP + PMAX);
            chk(ready_o && csn_o, "R4", "idle after timeout", ready_o, 1);
            chk(value_o == held, "R4", "outputs held", value_o, held);
            @(negedge clk);
            chk(!tout_o, "R4", "strobe one cycle", tout_o, 0);
        end else begin
            exp_val = word[29] ? longint'(word[28:5]) : longint'(word[28:5]) - 64'sd16777216;
            chk(got_done, "R8", "completion seen", got_done, 1);
            chk(csn_o == 1'b1, "R8", "cs high at completion", csn_o, 1);
            chk(s_rises == 32, "R5", "clock pulses", s_rises, 32);
            chk(s_cap == {cfg, 19'b0}, "R6", "sent bits", s_cap, {cfg, 19'b0});
            chk(first_gap > SETUP, "R2", "setup before clock", first_gap, SETUP + 1);
            chk(first_gap <= busy + SETUP + HALF + 4, "R3", "prompt start", first_gap, busy + SETUP + HALF + 4);
            chk(data_o == word[28:5], "R7", "result field", data_o, word[28:5]);
            chk(frame_err_o == (word[31] | word[30]), "R9", "frame error", frame_err_o, word[30]);
            chk(over_o == (word[29] & word[28]), "R10", "over-range", over_o, word[29] & word[28]);
            chk(under_o == (!word[29] && !word[28]), "R10", "under-range", under_o, !word[29] && !word[28]);
            chk(sign_o == word[29], "R11", "sign", sign_o, word[29]);
            chk(sub_o == word[4:0], "R11", "sub bits", sub_o, word[4:0]);
            chk(longint'(value_o) == exp_val, "R11", "signed value", value_o, exp_val);
            held = value_o;
            @(negedge clk);
            chk(!done_o, "R8", "completion one cycle", done_o, 0);
            repeat (10) @(negedge clk);
            chk(value_o == held, "R8", "value held", value_o, held);
            if (extra_start) begin
                for (int k = 0; k < 20; k++) begin
                    @(negedge clk);
                    if (!csn_o || !ready_o) begin
                        chk(0, "R12", "restart from ignored request", csn_o, 1);
                        break;
                    end
                end
                chk(csn_o && ready_o, "R12", "idle after ignored request", csn_o, 1);
            end
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        fork
            slave_loop();
        join_none
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(csn_o == 1'b1, "R1", "cs after reset", csn_o, 1);
        chk(sclk_o == 1'b0, "R1", "sclk after reset", sclk_o, 0);
        chk(ready_o == 1'b1, "R1", "ready after reset", ready_o, 1);
        chk(!done_o && !tout_o, "R1", "strobes after reset", done_o, 0);
        xact(13'h15A3, mk(1'b0, 1'b1, 24'h123456, 5'h15), 30, 0, 0);
        xact(13'h0F0F, mk(1'b0, 1'b0, 24'hFFFFFF, 5'h03), 0, 0, 0);
        xact(13'h1FFF, mk(1'b0, 1'b1, 24'h800000, 5'h0A), 3, 0, 0);
        xact(13'h0000, mk(1'b0, 1'b0, 24'h7FFFFF, 5'h11), 10, 0, 0);
        xact(13'h0AAA, mk(1'b1, 1'b1, 24'h000000, 5'h1F), 2, 0, 0);
        xact(13'h1234, mk(1'b0, 1'b1, 24'h000001, 5'h00), 1000, 0, 1);
        xact(13'h0001, mk(1'b0, 1'b0, 24'h800000, 5'h00), 5, 1, 0);
        xact(13'h1555, mk(1'b0, 1'b1, 24'h5A5A5A, 5'h0C), 55, 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule